// File: doc/BRIEF.md
# Adaptive Insertion Tag Store

This block is the tag side of a set-associative cache. It keeps one ordered recency list for each set. When a new line is filled, the block can place it at either end of that list, so the insertion position is separate from the promotion that a hit causes. Each lookup presents a set index and a tag. One cycle later the block reports whether the lookup hit, and which way was hit or filled.

Software or a wrapper picks one of three static fill placements:
- Most-recent end of the list (classic LRU).
- Least-recent end of the list.
- A mixed placement that sends about one fill in 32 to the most-recent end, using a pseudo-random draw.

With the adaptive enable set, the block chooses between classic LRU and the mixed placement at run time. A quarter of the sets always use classic LRU and another quarter always use the mixed placement. Misses in these two groups move a saturating selector. The selector then decides the placement for the remaining sets.

Top module: `adaptive_insert_cache`

## Requirements
- R1: When `req_valid` is high in a cycle, `rsp_valid` is high in the next cycle, carrying that lookup's `rsp_hit` and `rsp_way`. When no request is made, `rsp_valid` is low in the next cycle.
- R2: A lookup hits when a valid way of the addressed set holds the requested tag. `rsp_hit` is then 1, `rsp_way` names that way, and the way moves to the most-recent end of the set's list under every placement.
- R3: On a miss, the lowest-numbered invalid way of the set is filled. If the set has no invalid way, the way at the least-recent end of the list is evicted and refilled. `rsp_way` names the filled way and `rsp_hit` is 0.
- R4: With `policy_sel` = 0, a filled way goes to the most-recent end, and the ways that were ahead of it each age by one place.
- R5: With `policy_sel` = 1, a filled way goes to the least-recent end. It leaves that end only when it is later hit, so repeated misses to a full set keep replacing the same way.
- R6: With `policy_sel` = 2 or 3, a fill goes to the most-recent end only when the low 5 bits of a 16-bit shift register are all zero; otherwise it goes to the least-recent end.
  - The register starts at 0xACE1 after reset.
  - On every miss, whatever the placement, it shifts one place toward its MSB. The bit entering bit 0 is the XOR of bits 15, 13, 12 and 10.
  - The placement decision uses the value held before that shift. Hits and idle cycles leave the register unchanged.
- R7: With `dyn_en` high, the placement ignores `policy_sel`:
  - Sets whose index has bits [1:0] = 00 always use the R4 placement.
  - Sets whose index has bits [1:0] = 11 always use the R6 placement.
  - All other sets use R6 while the selector MSB is 1, and R4 while it is 0.
- R8: The selector is a 10-bit saturating counter that resets to 511. While `dyn_en` is high, it counts up on a miss in a set with index bits [1:0] = 00 and down on a miss in a set with index bits [1:0] = 11. It holds at 1023 and 0, and holds its value whenever `dyn_en` is low.
- R9: Synchronous active-high reset clears all valid bits and `rsp_valid`. It also orders every set's list as way 0 at the most-recent end through way 7 at the least-recent end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_set | input | SET_W (6) | Set index of the lookup |
| req_tag | input | TAG_W (12) | Tag of the lookup |
| policy_sel | input | 2 | Static placement: 0 most-recent, 1 least-recent, 2/3 mixed |
| dyn_en | input | 1 | Enables run-time choice between placements |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_way | output | WAY_W (3) | Hit way, or the way that was filled |

## Verification
The assertions check the properties that hold on every cycle:
- The response timing of R1.
- That the pseudo-random register moves only on requests and never reaches zero.
- That the selector steps by at most one per cycle and freezes while the adaptive mode is off.

Which way is chosen, where it is placed in the list, and how the selector's saturation and sign affect the non-sampled sets can only be seen across a sequence of accesses. The bench's directed scenarios check these against a reference model of the recency lists.

// File: rtl/aic_pkg.sv
package aic_pkg;
  typedef enum logic [1:0] {
    PL_MRU = 2'd0,
    PL_LRU = 2'd1,
    PL_MIX = 2'd2
  } place_e;

  function automatic place_e decode_place(input logic [1:0] sel);
    case (sel)
      2'd0:    decode_place = PL_MRU;
      2'd1:    decode_place = PL_LRU;
      default: decode_place = PL_MIX;
    endcase
  endfunction
endpackage

// File: rtl/aic_lfsr.sv
module aic_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= SEED;
    else if (step) q <= {q[W-2:0], ^(q & TAPS)};
  end
endmodule

// File: rtl/aic_selector.sv
module aic_selector #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV  = '1;
  localparam logic [W-1:0] START = MAXV >> 1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= START;
    else if (inc && cnt != MAXV)  cnt <= cnt + 1'b1;
    else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/aic_recency.sv
module aic_recency #(
  parameter int NWAYS = 8,
  parameter int WAY_W = 3
) (
  input  logic [NWAYS*WAY_W-1:0] cur,
  input  logic [WAY_W-1:0]       way,
  input  logic                   to_mru,
  output logic [NWAYS*WAY_W-1:0] nxt
);
  logic [WAY_W-1:0] pos;

  always_comb begin
    pos = '0;
    for (int i = 0; i < NWAYS; i++)
      if (cur[i*WAY_W +: WAY_W] == way) pos = WAY_W'(i);
  end

  for (genvar i = 0; i < NWAYS; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign nxt[0 +: WAY_W] = to_mru ? way :
             ((pos == '0) ? cur[WAY_W +: WAY_W] : cur[0 +: WAY_W]);
    end else if (i == NWAYS-1) begin : g_tail
      assign nxt[i*WAY_W +: WAY_W] = !to_mru ? way :
             ((pos == WAY_W'(i)) ? cur[(i-1)*WAY_W +: WAY_W] : cur[i*WAY_W +: WAY_W]);
    end else begin : g_mid
      assign nxt[i*WAY_W +: WAY_W] = to_mru ?
             ((WAY_W'(i) <= pos) ? cur[(i-1)*WAY_W +: WAY_W] : cur[i*WAY_W +: WAY_W]) :
             ((WAY_W'(i) >= pos) ? cur[(i+1)*WAY_W +: WAY_W] : cur[i*WAY_W +: WAY_W]);
    end
  end
endmodule

// File: rtl/adaptive_insert_cache.sv
module adaptive_insert_cache
  import aic_pkg::*;
#(
  parameter int NWAYS  = 8,
  parameter int NSETS  = 64,
  parameter int TAG_W  = 12,
  parameter int SEL_W  = 10,
  parameter int RND_W  = 16,
  parameter int THR_W  = 5,
  parameter int WAY_W  = $clog2(NWAYS),
  parameter int SET_W  = $clog2(NSETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [1:0]       policy_sel,
  input  logic             dyn_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [WAY_W-1:0] rsp_way
);
  localparam int ROW_W = NWAYS * WAY_W;
  localparam int TROW  = NWAYS * TAG_W;

  function automatic logic [ROW_W-1:0] ident_row();
    logic [ROW_W-1:0] r;
    for (int w = 0; w < NWAYS; w++) r[w*WAY_W +: WAY_W] = WAY_W'(w);
    return r;
  endfunction

  logic [ROW_W-1:0] stk_mem [NSETS];
  logic [TROW-1:0]  tag_mem [NSETS];
  logic [NWAYS-1:0] vld_mem [NSETS];

  logic [ROW_W-1:0] row_stk, row_nxt;
  logic [TROW-1:0]  row_tag;
  logic [NWAYS-1:0] row_vld;
  logic             hit, inv_any, to_mru, lead_mru, lead_mix, miss;
  logic [WAY_W-1:0] hit_way, inv_way, use_way;
  logic [SEL_W-1:0] sel_cnt;
  logic [RND_W-1:0] lfsr_q;
  place_e           eff_place;

  assign row_stk  = stk_mem[req_set];
  assign row_tag  = tag_mem[req_set];
  assign row_vld  = vld_mem[req_set];
  assign lead_mru = (req_set[1:0] == 2'b00);
  assign lead_mix = (req_set[1:0] == 2'b11);

  always_comb begin
    hit = 1'b0; hit_way = '0; inv_any = 1'b0; inv_way = '0;
    for (int w = NWAYS-1; w >= 0; w--) begin
      if (row_vld[w] && row_tag[w*TAG_W +: TAG_W] == req_tag) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (!row_vld[w]) begin
        inv_any = 1'b1; inv_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (!dyn_en)       eff_place = decode_place(policy_sel);
    else if (lead_mru) eff_place = PL_MRU;
    else if (lead_mix) eff_place = PL_MIX;
    else               eff_place = sel_cnt[SEL_W-1] ? PL_MIX : PL_MRU;
  end

  assign miss    = req_valid && !hit;
  assign use_way = hit ? hit_way : (inv_any ? inv_way : row_stk[ROW_W-1 -: WAY_W]);
  assign to_mru  = hit || eff_place == PL_MRU ||
                   (eff_place == PL_MIX && lfsr_q[THR_W-1:0] == '0);

  aic_recency #(.NWAYS(NWAYS), .WAY_W(WAY_W)) u_recency (
    .cur(row_stk), .way(use_way), .to_mru(to_mru), .nxt(row_nxt));

  aic_lfsr #(.W(RND_W)) u_lfsr (
    .clk(clk), .rst(rst), .step(miss), .q(lfsr_q));

  aic_selector #(.W(SEL_W)) u_sel (
    .clk(clk), .rst(rst),
    .inc(miss && dyn_en && lead_mru),
    .dec(miss && dyn_en && lead_mix),
    .cnt(sel_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) begin
        stk_mem[s] <= ident_row();
        vld_mem[s] <= '0;
      end
    end else if (req_valid) begin
      stk_mem[req_set]          <= row_nxt;
      vld_mem[req_set][use_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) tag_mem[req_set][use_way*TAG_W +: TAG_W] <= req_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && hit;
      rsp_way   <= use_way;
    end
  end
endmodule

// File: rtl/aic_checks.sv
module aic_checks #(
  parameter int SEL_W = 10,
  parameter int RND_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             rsp_valid,
  input logic             dyn_en,
  input logic [SEL_W-1:0] sel_cnt,
  input logic [RND_W-1:0] lfsr_q
);
  a_r1_rsp_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r6_rng_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(lfsr_q));

  a_r6_rng_nonzero: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> lfsr_q != '0);

  a_r8_sel_step: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (sel_cnt == $past(sel_cnt) ||
              sel_cnt == $past(sel_cnt) + SEL_W'(1) ||
              sel_cnt == $past(sel_cnt) - SEL_W'(1)));

  a_r8_sel_frozen: assert property (@(posedge clk) disable iff (rst)
    !dyn_en |=> $stable(sel_cnt));
endmodule

bind adaptive_insert_cache aic_checks #(.SEL_W(SEL_W), .RND_W(RND_W)) u_aic_checks (
  .clk(clk), .rst(rst), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .dyn_en(dyn_en), .sel_cnt(sel_cnt), .lfsr_q(lfsr_q));

// File: tb/adaptive_insert_cache_bench.sv
module adaptive_insert_cache_bench;
  localparam int NW = 8, NS = 64;

  logic        clk = 1'b0;
  logic        rst, req_valid, dyn_en;
  logic [5:0]  req_set;
  logic [11:0] req_tag;
  logic [1:0]  policy_sel;
  logic        rsp_valid, rsp_hit;
  logic [2:0]  rsp_way;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  bit          m_vld [NS][NW];
  int          m_tag [NS][NW];
  int          m_stk [NS][NW];
  logic [15:0] m_lfsr;
  int          m_sel;
  int          next_tag;

  always #5 clk = ~clk;

  adaptive_insert_cache u_adaptive_insert_cache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
    .req_tag(req_tag), .policy_sel(policy_sel), .dyn_en(dyn_en),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way));

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0; req_set = '0; req_tag = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < NS; s++)
      for (int w = 0; w < NW; w++) begin
        m_vld[s][w] = 0; m_tag[s][w] = 0; m_stk[s][w] = w;
      end
    m_lfsr = 16'hACE1; m_sel = 511;
  endtask

  task automatic model(input int s, input int t, output bit h, output int way);
    int pol, p; bit mru;
    h = 0; way = -1;
    for (int w = 0; w < NW; w++)
      if (m_vld[s][w] && m_tag[s][w] == t) begin h = 1; way = w; end
    if (!h) begin
      for (int w = NW-1; w >= 0; w--) if (!m_vld[s][w]) way = w;
      if (way < 0) way = m_stk[s][NW-1];
    end
    if (dyn_en) pol = (s % 4 == 0) ? 0 : (s % 4 == 3) ? 2 : (m_sel >= 512 ? 2 : 0);
    else        pol = (policy_sel == 0) ? 0 : (policy_sel == 1) ? 1 : 2;
    mru = h || pol == 0 || (pol == 2 && m_lfsr[4:0] == 5'd0);
    if (!h) begin
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
      if (dyn_en && s % 4 == 0 && m_sel < 1023) m_sel++;
      if (dyn_en && s % 4 == 3 && m_sel > 0)    m_sel--;
    end
    p = 0;
    for (int i = 0; i < NW; i++) if (m_stk[s][i] == way) p = i;
    if (mru) begin
      for (int i = p; i > 0; i--) m_stk[s][i] = m_stk[s][i-1];
      m_stk[s][0] = way;
    end else begin
      for (int i = p; i < NW-1; i++) m_stk[s][i] = m_stk[s][i+1];
      m_stk[s][NW-1] = way;
    end
    m_vld[s][way] = 1; m_tag[s][way] = t;
  endtask

  task automatic access(input int s, input int t, input string rq, output int got);
    bit h; int w;
    model(s, t, h, w);
    @(negedge clk);
    req_valid = 1'b1; req_set = 6'(s); req_tag = 12'(t);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, rq, "rsp_valid", int'(rsp_valid), 1);
    chk(rsp_hit === h, rq, "rsp_hit", int'(rsp_hit), int'(h));
    chk(int'(rsp_way) == w, rq, "rsp_way", int'(rsp_way), w);
    got = int'(rsp_way);
  endtask

  function automatic int fresh();
    next_tag++;
    return next_tag;
  endfunction

  task automatic t_reset_idle();
    int g;
    do_reset();
    chk(rsp_valid === 1'b0, "R9", "rsp_valid after reset", int'(rsp_valid), 0);
    access(9, fresh(), "R9", g);
    chk(g == 0, "R9", "first fill way", g, 0);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R1", "idle rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_fill_hit();
    int g, tg[NW];
    do_reset(); policy_sel = 2'd0; dyn_en = 1'b0;
    for (int w = 0; w < NW; w++) begin
      tg[w] = fresh();
      access(5, tg[w], "R3", g);
      chk(g == w, "R3", "invalid fill order", g, w);
    end
    access(5, tg[0], "R2", g);
    chk(rsp_hit === 1'b1 && g == 0, "R2", "hit way", g, 0);
    access(5, fresh(), "R3", g);
    chk(g == 1, "R3", "victim after hit promotion", g, 1);
  endtask

  task automatic t_conventional();
    int g;
    do_reset(); policy_sel = 2'd0; dyn_en = 1'b0;
    for (int w = 0; w < NW; w++) access(12, fresh(), "R4", g);
    access(12, fresh(), "R4", g);
    chk(g == 0, "R4", "first eviction", g, 0);
    access(12, fresh(), "R4", g);
    chk(g == 1, "R4", "second eviction", g, 1);
  endtask

  task automatic t_lru_insert();
    int g, g2;
    do_reset(); policy_sel = 2'd1; dyn_en = 1'b0;
    for (int w = 0; w < NW; w++) access(20, fresh(), "R5", g);
    access(20, fresh(), "R5", g);
    access(20, fresh(), "R5", g2);
    chk(g == g2, "R5", "same victim on repeated misses", g2, g);
    for (int k = 0; k < 6; k++) access(20, fresh(), "R5", g2);
  endtask

  task automatic t_mixed();
    int g;
    do_reset(); policy_sel = 2'd2; dyn_en = 1'b0;
    for (int k = 0; k < 300; k++) access(33, fresh(), "R6", g);
    policy_sel = 2'd3;
    for (int k = 0; k < 100; k++) access(34, fresh(), "R6", g);
    for (int k = 0; k < 40; k++) access(34, m_tag[34][k % NW], "R6", g);
  endtask

  task automatic t_dynamic();
    int g;
    do_reset(); policy_sel = 2'd1; dyn_en = 1'b1;
    for (int w = 0; w < NW; w++) access(1, fresh(), "R7", g);
    access(1, fresh(), "R7", g);
    chk(g == 0, "R7", "follower uses most-recent fill", g, 0);
    access(1, fresh(), "R7", g);
    chk(g == 1, "R7", "follower second eviction", g, 1);
    access(0, fresh(), "R8", g);
    for (int k = 0; k < 60; k++) access(2, fresh(), "R7", g);
    for (int k = 0; k < 60; k++) access(3, fresh(), "R7", g);
    for (int k = 0; k < 60; k++) access(4, fresh(), "R7", g);
  endtask

  task automatic t_saturate();
    int g;
    do_reset(); policy_sel = 2'd0; dyn_en = 1'b1;
    for (int k = 0; k < 520; k++) access(7, fresh(), "R8", g);
    access(8, fresh(), "R8", g);
    access(8, fresh(), "R8", g);
    for (int w = 0; w < NW; w++) access(6, fresh(), "R8", g);
    access(6, fresh(), "R8", g);
    chk(g == 0, "R8", "low saturation keeps followers on most-recent fill", g, 0);
    access(6, fresh(), "R8", g);
    chk(g == 1, "R8", "low saturation second eviction", g, 1);
    dyn_en = 1'b0;
    for (int k = 0; k < 20; k++) access(11, fresh(), "R8", g);
    dyn_en = 1'b1;
    for (int k = 0; k < 20; k++) access(10, fresh(), "R8", g);
  endtask

  initial begin
    next_tag = 0; policy_sel = 2'd0; dyn_en = 1'b0;
    t_reset_idle();
    t_fill_hit();
    t_conventional();
    t_lru_insert();
    t_mixed();
    t_dynamic();
    t_saturate();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule